// File: doc/BRIEF.md
# Multichannel Sample Word Framer

This block sits between four per-channel sample sources and a serial shifter in run mode. Each source delivers a 16-bit filtered sample with a one-cycle strobe and two range flags (over range, under range). The framer keeps one pending sample per channel, picks the next channel to send when the shifter asks for a word, and packs the result into a 24-bit word. That word carries a parity bit, the channel number, a fresh-data marker and both live and sticky range flags above the sample.

The shifter asks for a word with `word_req`. The framer answers one cycle later with a single-cycle `word_load` and the packed word on `word_out`. If no enabled channel holds fresh data, the framer re-sends a stored sample with the fresh-data marker cleared, so the shifter always gets a word while any channel is enabled. Separately, the framer drives an external ready line that follows the strobe of one channel chosen by a 2-bit select. Once set, that line stays set until the host pulls chip select low.

Top module: `smp_word_framer`

## Requirements
- R1: Word layout: bit 23 parity, bits 22:21 channel number (0 = first channel through 3 = fourth channel), bit 20 fresh-data marker, bit 19 sticky over-range, bit 18 live over-range, bit 17 sticky under-range, bit 16 live under-range, bits 15:0 sample.
- R2: Parity is even: bit 23 equals the XOR of bits 22:0, so every loaded word has an even number of ones.
- R3: A `word_req` sampled high at a clock edge gives `word_load` high for exactly the following cycle, with the word on `word_out`, provided at least one channel is enabled; otherwise no word is loaded. `word_out` holds its last value between loads.
- R4: Enabled channels holding fresh data are served round-robin, starting with the channel after the last one served; after reset the first channel is first in line.
- R5: When no enabled channel holds fresh data, a request re-sends the stored sample of the next enabled channel in round-robin order with the fresh-data marker 0 and its stored live flags.
- R6: A channel whose enable bit is 0 is never chosen; its fresh sample stays pending and is sent once the channel is enabled again.
- R7: A strobe on a channel that already holds fresh data replaces the sample and sets that channel's sticky over-range flag. A strobe in the same cycle that the channel's word is loaded is not an overwrite: the old sample goes out and the new one becomes pending.
- R8: Live range flags are stored with each sample. Sticky flags are set by a strobe whose matching live flag is high and are cleared when a word for that channel is loaded.
- R9: The ready line `drdy_out` goes high the cycle after a strobe on the channel named by `fast_sel` (0 to 3); strobes on other channels do not touch it.
- R10: Once high, `drdy_out` stays high until a falling edge of `cs_n` is seen at a clock edge, and is low from the following cycle; a strobe of the chosen channel at that same edge keeps it high.
- R11: After reset `word_load`, `drdy_out` and `word_out` are 0 and no channel holds fresh data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_en | input | 4 | Per-channel enable |
| smp_vld | input | 4 | Per-channel sample strobe |
| smp_data | input | 64 | Samples, channel n in bits 16n+15:16n |
| smp_ovf | input | 4 | Live over-range flag, valid with strobe |
| smp_unf | input | 4 | Live under-range flag, valid with strobe |
| fast_sel | input | 2 | Channel that drives the ready line |
| cs_n | input | 1 | Host chip select, active low |
| word_req | input | 1 | Shifter request for the next word |
| word_out | output | 24 | Packed output word |
| word_load | output | 1 | One-cycle strobe, word_out is new |
| drdy_out | output | 1 | External ready line |

## Verification
The hardest case to reach is a channel whose sticky flags and fresh state change in the same cycle its word is loaded. The bench strobes a channel while its earlier sample is still waiting, then requests while a second strobe lands on the same edge. It also parks a pending sample behind a disabled enable bit and releases it later, and drives more requests than there are fresh samples so that the re-send path walks the round-robin order.

// File: rtl/sfr_pkg.sv
// Package for the sample word framer.
// Holds the offsets of the status byte above the sample and the per-channel
// status record. Assumes the channel number field is two bits wide.
package sfr_pkg;

    localparam int ID_W    = 2;   // channel number field width
    localparam int OFS_UN  = 0;   // offsets above the sample field
    localparam int OFS_LUN = 1;
    localparam int OFS_OV  = 2;
    localparam int OFS_LOV = 3;
    localparam int OFS_NEW = 4;
    localparam int OFS_ID  = 5;
    localparam int OFS_PAR = 7;
    localparam int HDR_W   = 8;

    typedef struct packed {
        logic ov;    // live over-range stored with the sample
        logic un;    // live under-range stored with the sample
        logic lov;   // sticky over-range
        logic lun;   // sticky under-range
    } slot_flags_t;

endpackage

// File: rtl/sfr_slot.sv
// One channel's holding slot.
// Keeps the last sample with its live flags, a fresh marker and sticky
// range flags. Assumes 'take' is high only in the cycle the slot's word is
// loaded; the loaded word uses the values held before that edge.
module sfr_slot
    import sfr_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld,
    input  logic [SW-1:0] data,
    input  logic          ovf,
    input  logic          unf,
    input  logic          take,
    output logic          pend,
    output logic [SW-1:0] data_q,
    output slot_flags_t   flags_q
);

    logic clash;

    // a strobe on a slot that stays pending is an overwrite
    always_comb clash = vld && pend && !take;

    // fresh marker: set by strobe, cleared by load
    always_ff @(posedge clk) begin
        if (!rst_n)    pend <= 1'b0;
        else if (vld)  pend <= 1'b1;
        else if (take) pend <= 1'b0;
    end

    // sample and live flags captured on strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q     <= '0;
            flags_q.ov <= 1'b0;
            flags_q.un <= 1'b0;
        end else if (vld) begin
            data_q     <= data;
            flags_q.ov <= ovf;
            flags_q.un <= unf;
        end
    end

    // sticky flags: cleared on load, set by flags or overwrite
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q.lov <= 1'b0;
            flags_q.lun <= 1'b0;
        end else begin
            flags_q.lov <= (flags_q.lov && !take) || (vld && (ovf || clash));
            flags_q.lun <= (flags_q.lun && !take) || (vld && unf);
        end
    end

endmodule

// File: rtl/sfr_rr.sv
// Round-robin channel picker.
// Prefers enabled channels with fresh data; otherwise falls back to the next
// enabled channel for a re-send. Search starts after the last channel served.
// Assumes NCH is at most 2**ID_W.
module sfr_rr
    import sfr_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [NCH-1:0]  ch_en,
    input  logic [NCH-1:0]  pend,
    output logic            grant,
    output logic [ID_W-1:0] grant_id,
    output logic            grant_new
);

    logic [ID_W-1:0] last_q;
    logic            hit_p, hit_e;
    logic [ID_W-1:0] id_p, id_e;

    // two rotating searches: fresh-and-enabled, then enabled only
    always_comb begin
        hit_p = 1'b0;
        hit_e = 1'b0;
        id_p  = '0;
        id_e  = '0;
        for (int k = 1; k <= NCH; k++) begin
            logic [ID_W-1:0] idx;
            idx = ID_W'((int'(last_q) + k) % NCH);
            if (!hit_p && ch_en[idx] && pend[idx]) begin
                hit_p = 1'b1;
                id_p  = idx;
            end
            if (!hit_e && ch_en[idx]) begin
                hit_e = 1'b1;
                id_e  = idx;
            end
        end
    end

    // grant outputs for this request
    always_comb begin
        grant     = req && hit_e;
        grant_id  = hit_p ? id_p : id_e;
        grant_new = hit_p;
    end

    // remember the channel served
    always_ff @(posedge clk) begin
        if (!rst_n)     last_q <= ID_W'(NCH - 1);
        else if (grant) last_q <= grant_id;
    end

endmodule

// File: rtl/sfr_pack.sv
// Word builder: places channel number, markers and sample, then adds the
// even parity bit over everything below it. Purely combinational.
module sfr_pack
    import sfr_pkg::*;
#(
    parameter int SW = 16,
    localparam int WW = SW + HDR_W
) (
    input  logic [ID_W-1:0] id,
    input  logic            fresh,
    input  slot_flags_t     flags,
    input  logic [SW-1:0]   data,
    output logic [WW-1:0]   word
);

    logic [WW-2:0] body;

    // assemble the fields, then parity on top
    always_comb begin
        body                               = '0;
        body[SW-1:0]                       = data;
        body[SW+OFS_UN]                    = flags.un;
        body[SW+OFS_LUN]                   = flags.lun;
        body[SW+OFS_OV]                    = flags.ov;
        body[SW+OFS_LOV]                   = flags.lov;
        body[SW+OFS_NEW]                   = fresh;
        body[SW+OFS_ID +: ID_W]            = id;
        word                               = {^body, body};
    end

endmodule

// File: rtl/sfr_ready.sv
// External ready line.
// Set by a strobe of the chosen channel, held until a falling edge of chip
// select is seen; a strobe at that same edge wins over the clear.
module sfr_ready (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_vld,
    input  logic cs_n,
    output logic drdy
);

    logic cs_q;

    // previous chip select level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b1;
        else        cs_q <= cs_n;
    end

    // sticky ready flag
    always_ff @(posedge clk) begin
        if (!rst_n) drdy <= 1'b0;
        else        drdy <= fast_vld || (drdy && !(cs_q && !cs_n));
    end

endmodule

// File: rtl/smp_word_framer.sv
// Multichannel sample word framer, top level.
// One holding slot per channel, a round-robin picker, a word builder and the
// ready line. The word and its load strobe are registered, so a request at
// one edge produces the word in the following cycle.
module smp_word_framer
    import sfr_pkg::*;
#(
    parameter int NCH = 4,
    parameter int SW  = 16,
    localparam int WW = SW + HDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  ch_en,
    input  logic [NCH-1:0]  smp_vld,
    input  logic [NCH*SW-1:0] smp_data,
    input  logic [NCH-1:0]  smp_ovf,
    input  logic [NCH-1:0]  smp_unf,
    input  logic [ID_W-1:0] fast_sel,
    input  logic            cs_n,
    input  logic            word_req,
    output logic [WW-1:0]   word_out,
    output logic            word_load,
    output logic            drdy_out
);

    logic [NCH-1:0]  pend;
    logic [NCH-1:0]  take;
    logic [SW-1:0]   slot_data [NCH];
    slot_flags_t     slot_flg  [NCH];
    logic            grant, grant_new;
    logic [ID_W-1:0] grant_id;
    logic [WW-1:0]   word_d;

    // one holding slot per channel
    for (genvar c = 0; c < NCH; c++) begin : g_slot
        always_comb take[c] = grant && (grant_id == ID_W'(c));

        sfr_slot #(.SW(SW)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .vld     (smp_vld[c]),
            .data    (smp_data[c*SW +: SW]),
            .ovf     (smp_ovf[c]),
            .unf     (smp_unf[c]),
            .take    (take[c]),
            .pend    (pend[c]),
            .data_q  (slot_data[c]),
            .flags_q (slot_flg[c])
        );
    end

    sfr_rr #(.NCH(NCH)) u_rr (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (word_req),
        .ch_en     (ch_en),
        .pend      (pend),
        .grant     (grant),
        .grant_id  (grant_id),
        .grant_new (grant_new)
    );

    sfr_pack #(.SW(SW)) u_pack (
        .id    (grant_id),
        .fresh (grant_new),
        .flags (slot_flg[grant_id]),
        .data  (slot_data[grant_id]),
        .word  (word_d)
    );

    sfr_ready u_ready (
        .clk      (clk),
        .rst_n    (rst_n),
        .fast_vld (smp_vld[fast_sel]),
        .cs_n     (cs_n),
        .drdy     (drdy_out)
    );

    // output word register and load strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out  <= '0;
            word_load <= 1'b0;
        end else begin
            word_load <= grant;
            if (grant) word_out <= word_d;
        end
    end

endmodule

// File: rtl/sfr_checker.sv
// Property checker for the sample word framer, bound to the top.
// Watches ports only and keeps its own one-cycle history registers.
module sfr_checker
    import sfr_pkg::*;
#(
    parameter int NCH = 4,
    parameter int SW  = 16,
    localparam int WW = SW + HDR_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NCH-1:0]  ch_en,
    input logic [NCH-1:0]  smp_vld,
    input logic [ID_W-1:0] fast_sel,
    input logic            cs_n,
    input logic            word_req,
    input logic [WW-1:0]   word_out,
    input logic            word_load,
    input logic            drdy_out
);

    logic [NCH-1:0] en_q;
    logic           req_q;
    logic           fast_q;

    // history of request, enables and chosen strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            req_q  <= 1'b0;
            fast_q <= 1'b0;
        end else begin
            en_q   <= ch_en;
            req_q  <= word_req;
            fast_q <= smp_vld[fast_sel];
        end
    end

    assert_load_follows_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_load |-> req_q);

    assert_even_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        word_load |-> ((^word_out) == 1'b0));

    assert_enabled_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        word_load |-> en_q[word_out[SW+OFS_ID +: ID_W]]);

    assert_ready_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drdy_out) |-> fast_q);

    assert_ready_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (drdy_out && cs_n) |=> drdy_out);

    assert_ready_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && !smp_vld[fast_sel]) |=> !drdy_out);

endmodule

bind smp_word_framer sfr_checker #(.NCH(NCH), .SW(SW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_en     (ch_en),
    .smp_vld   (smp_vld),
    .fast_sel  (fast_sel),
    .cs_n      (cs_n),
    .word_req  (word_req),
    .word_out  (word_out),
    .word_load (word_load),
    .drdy_out  (drdy_out)
);

// File: tb/smp_word_framer_tb.sv
// Bench for the sample word framer: a vector table walked by one loop,
// then directed tests for flags, enables, same-edge cases and the ready line.
module smp_word_framer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int SW  = 16;

    typedef struct packed {
        logic [3:0]  vld;
        logic [15:0] base;
        logic        req;
        logic        ld;
        logic [1:0]  id;
        logic        nw;
        logic        lov;
        logic [15:0] dat;
    } vec_t;

    // R4 round-robin, R5 re-send, R7 overwrite; all channels enabled
    localparam vec_t VECS [14] = '{
        '{4'b0001, 16'h1000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0000},
        '{4'b0000, 16'h0000, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 16'h1000},
        '{4'b0110, 16'h2000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0000},
        '{4'b0000, 16'h0000, 1'b1, 1'b1, 2'd1, 1'b1, 1'b0, 16'h2001},
        '{4'b1000, 16'h3000, 1'b1, 1'b1, 2'd2, 1'b1, 1'b0, 16'h2002},
        '{4'b0000, 16'h0000, 1'b1, 1'b1, 2'd3, 1'b1, 1'b0, 16'h3003},
        '{4'b0000, 16'h0000, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 16'h1000},
        '{4'b0010, 16'h4000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0000},
        '{4'b0010, 16'h5000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0000},
        '{4'b0000, 16'h0000, 1'b1, 1'b1, 2'd1, 1'b1, 1'b1, 16'h5001},
        '{4'b0000, 16'h0000, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 16'h2002},
        '{4'b0000, 16'h0000, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 16'h3003},
        '{4'b0000, 16'h0000, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 16'h1000},
        '{4'b0000, 16'h0000, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 16'h5001}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NCH-1:0]    ch_en;
    logic [NCH-1:0]    smp_vld;
    logic [NCH*SW-1:0] smp_data;
    logic [NCH-1:0]    smp_ovf;
    logic [NCH-1:0]    smp_unf;
    logic [1:0]        fast_sel;
    logic              cs_n;
    logic              word_req;
    logic [23:0]       word_out;
    logic              word_load;
    logic              drdy_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smp_word_framer #(.NCH(NCH), .SW(SW)) u_dut (
        .clk, .rst_n, .ch_en, .smp_vld, .smp_data, .smp_ovf, .smp_unf,
        .fast_sel, .cs_n, .word_req, .word_out, .word_load, .drdy_out
    );

    // expected word from the R1 layout and R2 even parity
    function automatic logic [23:0] mk(input logic [1:0] id, input logic nw,
        input logic lov, input logic ov, input logic lun, input logic un,
        input logic [15:0] d);
        logic [22:0] b;
        b = {id, nw, lov, ov, lun, un, d};
        return {^b, b};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // drive one cycle of inputs at the falling edge, return at the next one
    task automatic step(input logic [3:0] vld, input logic [15:0] base,
        input logic [3:0] ovf, input logic [3:0] unf, input logic req);
        smp_vld  = vld;
        smp_ovf  = ovf;
        smp_unf  = unf;
        word_req = req;
        for (int c = 0; c < NCH; c++) smp_data[c*SW +: SW] = base + 16'(c);
        @(negedge clk);
        smp_vld  = '0;
        smp_ovf  = '0;
        smp_unf  = '0;
        word_req = 1'b0;
    endtask

    task automatic chk_word(input string req, input logic [23:0] exp);
        chk(req, {31'd0, word_load}, 32'd1);
        chk(req, {8'd0, word_out}, {8'd0, exp});
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ch_en = 4'b1111; smp_vld = '0; smp_data = '0;
        smp_ovf = '0; smp_unf = '0; fast_sel = 2'd0; cs_n = 1'b1; word_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        chk("R11 load", {31'd0, word_load}, 32'd0);
        chk("R11 drdy", {31'd0, drdy_out}, 32'd0);
        chk("R11 word", {8'd0, word_out}, 32'd0);
        step(4'b0000, 16'h0, 4'h0, 4'h0, 1'b1);
        chk_word("R11 R5 stored zero resend", mk(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0));
        // restore R4 start order: channel 0 served, so next search begins at 1
        // (table below expects first pick at channel 0, so reset again)
        rst_n = 1'b0;
        step(4'b0000, 16'h0, 4'h0, 4'h0, 1'b0);
        rst_n = 1'b1;

        // table walk: R1 R2 R3 R4 R5 R7
        for (int i = 0; i < 14; i++) begin
            step(VECS[i].vld, VECS[i].base, 4'h0, 4'h0, VECS[i].req);
            if (VECS[i].ld)
                chk_word($sformatf("R4 R5 R7 vector %0d", i),
                    mk(VECS[i].id, VECS[i].nw, VECS[i].lov, 1'b0, 1'b0, 1'b0, VECS[i].dat));
            else
                chk($sformatf("R3 no load vector %0d", i), {31'd0, word_load}, 32'd0);
        end
        chk("R2 parity even", {31'd0, ^word_out}, 32'd0);

        // R8 sticky and live flags, R7 overwrite
        step(4'b0100, 16'h6000, 4'h0, 4'b0100, 1'b0);
        step(4'b0100, 16'h6100, 4'h0, 4'h0, 1'b0);
        step(4'b0000, 16'h0, 4'h0, 4'h0, 1'b1);
        chk_word("R7 R8 sticky set", mk(2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h6102));
        ch_en = 4'b0100;
        step(4'b0000, 16'h0, 4'h0, 4'h0, 1'b1);
        chk_word("R8 sticky cleared", mk(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h6102));
        step(4'b0100, 16'h6200, 4'b0100, 4'h0, 1'b0);
        step(4'b0000, 16'h0, 4'h0, 4'h0, 1'b1);
        chk_word("R8 live over-range", mk(2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h6202));

        // R6 disabled channel never picked, pending kept
        step(4'b0100, 16'h7000, 4'h0, 4'h0, 1'b0);
        ch_en = 4'b0001;
        step(4'b0000, 16'h0, 4'h0, 4'h0, 1'b1);
        chk_word("R6 disabled skipped", mk(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1000));
        ch_en = 4'b0000;
        step(4'b0000, 16'h0, 4'h0, 4'h0, 1'b1);
        chk("R3 no enabled channel", {31'd0, word_load}, 32'd0);
        chk("R3 word held", {8'd0, word_out}, {8'd0, mk(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1000)});
        ch_en = 4'b0100;
        step(4'b0000, 16'h0, 4'h0, 4'h0, 1'b1);
        chk_word("R6 pending released", mk(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h7002));

        // R7 strobe in the same cycle as the channel's load
        ch_en = 4'b0010;
        step(4'b0010, 16'h8000, 4'h0, 4'h0, 1'b0);
        step(4'b0010, 16'h8100, 4'h0, 4'h0, 1'b1);
        chk_word("R7 same edge old out", mk(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h8001));
        step(4'b0000, 16'h0, 4'h0, 4'h0, 1'b1);
        chk_word("R7 same edge new pending", mk(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h8101));

        // R9 R10 ready line
        fast_sel = 2'd1;
        cs_n = 1'b0;
        step(4'b0000, 16'h0, 4'h0, 4'h0, 1'b0);
        chk("R10 cleared on select", {31'd0, drdy_out}, 32'd0);
        cs_n = 1'b1;
        step(4'b0001, 16'h0, 4'h0, 4'h0, 1'b0);
        chk("R9 other channel ignored", {31'd0, drdy_out}, 32'd0);
        step(4'b0010, 16'h0, 4'h0, 4'h0, 1'b0);
        chk("R9 chosen channel sets", {31'd0, drdy_out}, 32'd1);
        repeat (3) step(4'b0000, 16'h0, 4'h0, 4'h0, 1'b0);
        chk("R10 held high", {31'd0, drdy_out}, 32'd1);
        cs_n = 1'b0;
        step(4'b0010, 16'h0, 4'h0, 4'h0, 1'b0);
        chk("R10 strobe wins at fall", {31'd0, drdy_out}, 32'd1);
        cs_n = 1'b1;
        step(4'b0000, 16'h0, 4'h0, 4'h0, 1'b0);
        cs_n = 1'b0;
        step(4'b0000, 16'h0, 4'h0, 4'h0, 1'b0);
        chk("R10 fall clears", {31'd0, drdy_out}, 32'd0);
        cs_n = 1'b1;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule